// File: doc/BRIEF.md
# Pseudo-Random Replacement Index Generator

This block supplies a pseudo-random slot number for replacing an entry in a translation lookaside buffer. The lower part of the buffer is "wired": those slots are reserved, so a replacement must never land there. Each accepted request advances a 32-bit linear congruential state once. The upper sixteen bits of the new state are reduced modulo the number of unreserved slots. The wired count is added to that remainder, so the result lands in the unreserved range.

The reduction runs as a restoring division, one quotient bit per cycle, under a small state machine. The wired count is captured in the cycle that accepts the request. `valid_o` rises only once the index is final. The index then holds steady until the next accepted request. Requests that arrive while a computation is running are dropped.

State machine. IDLE is entered on reset and accepts a request (IDLE→ADVANCE). ADVANCE steps the generator and loads the divider. It goes to REDUCE for a normal computation, or directly to DONE (ADVANCE→DONE) when the wired count leaves no legal range. REDUCE performs sixteen shift-subtract steps and then moves REDUCE→DONE. DONE drives `valid_o`. It stays in DONE while no request arrives and moves DONE→ADVANCE on a request.

Top module: `tlb_rand_idx`

## Requirements
- R1: On every accepted request, the 32-bit generator state is replaced by state × 314159 + 1, modulo 2^32. The state changes at no other time.
- R2: Synchronous reset (`rst` high at a rising edge) sets the generator state to zero, lowers `valid_o` and returns the machine to IDLE.
- R3: When the captured wired count W is below ENTRIES, the index equals (S[31:16] mod (ENTRIES − W)) + W. S is the state just produced by the advance for this request.
- R4: Every index presented with `valid_o` high and W below ENTRIES lies in the range W to ENTRIES − 1, inclusive.
- R5: When W is greater than or equal to ENTRIES, the index is ENTRIES − 1. The generator state still advances once.
- R6: While `valid_o` is high and no request is presented, `valid_o` stays high and `idx_o` keeps its value.
- R7: A request accepted while `valid_o` is high lowers `valid_o` on the following cycle.
- R8: A request seen in ADVANCE or REDUCE is ignored. It does not advance the state, does not restart the work and does not change the captured wired count.
- R9: `valid_o` rises after the 17th rising edge following the accepting edge on the normal path. On the clamp path of R5 it rises after the 1st rising edge.
- R10: The wired count is sampled only at the accepting edge. Later changes of `wired_i` do not affect that request's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe, accepted in IDLE or DONE |
| wired_i | input | $clog2(ENTRIES+1) | Number of reserved low slots |
| idx_o | output | $clog2(ENTRIES) | Replacement index |
| valid_o | output | 1 | High while idx_o holds a final result |

## Verification
The bound checker checks several properties on every cycle. It checks the generator recurrence and that the state stays still during REDUCE. It checks the range and clamp of every presented index, the hold of a valid result, and the drop of valid after a new request. The arithmetic value of each index, the latency on both paths and the independence from late wired changes are visible only in the bench scenarios. Those scenarios compare each result against a software model of the recurrence, including requests injected mid-computation and a reset during operation.

// File: rtl/tlb_rand_pkg.sv
`timescale 1ns/1ps
package tlb_rand_pkg;
    localparam int unsigned LCG_W  = 32;
    localparam int unsigned FOLD_W = 16;
    localparam logic [LCG_W-1:0] LCG_MUL = 32'd314159;
    localparam logic [LCG_W-1:0] LCG_INC = 32'd1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADVANCE = 2'd1,
        ST_REDUCE  = 2'd2,
        ST_DONE    = 2'd3
    } rnd_state_e;
endpackage

// File: rtl/tlb_rand_lcg.sv
`timescale 1ns/1ps
module tlb_rand_lcg #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] MUL = '0,
    parameter logic [W-1:0] INC = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    output logic [W-1:0] state_o,
    output logic [W-1:0] next_o
);
    logic [W-1:0] state_q;

    always_comb begin
        next_o = state_q * MUL + INC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (step_i) begin
            state_q <= next_o;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/tlb_rand_divstep.sv
`timescale 1ns/1ps
module tlb_rand_divstep #(
    parameter int unsigned DW = 6
) (
    input  logic [DW-1:0] part_i,
    input  logic          bit_i,
    input  logic [DW-1:0] divisor_i,
    output logic [DW-1:0] part_o
);
    logic [DW:0] trial;
    logic [DW:0] diff;

    always_comb begin
        trial = {part_i, bit_i};
        diff  = trial - {1'b0, divisor_i};
        if (trial >= {1'b0, divisor_i}) begin
            part_o = diff[DW-1:0];
        end else begin
            part_o = trial[DW-1:0];
        end
    end
endmodule

// File: rtl/tlb_rand_idx.sv
`timescale 1ns/1ps
module tlb_rand_idx #(
    parameter int unsigned ENTRIES = 48
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               req_i,
    input  logic [$clog2(ENTRIES+1)-1:0]       wired_i,
    output logic [$clog2(ENTRIES)-1:0]         idx_o,
    output logic                               valid_o
);
    import tlb_rand_pkg::*;

    localparam int unsigned IDXW = $clog2(ENTRIES);
    localparam int unsigned WW   = $clog2(ENTRIES + 1);
    localparam int unsigned CW   = $clog2(FOLD_W);
    localparam logic [WW-1:0]   ENT_W    = WW'(ENTRIES);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(ENTRIES - 1);
    localparam logic [CW-1:0]   LAST_CNT = CW'(FOLD_W - 1);

    rnd_state_e st_q, st_d;

    logic [WW-1:0]     wired_q;
    logic [WW-1:0]     divisor_q;
    logic [WW-1:0]     rem_q;
    logic [WW-1:0]     rem_nx;
    logic [FOLD_W-1:0] dividend_q;
    logic [CW-1:0]     cnt_q;
    logic [IDXW-1:0]   idx_q;
    logic [WW:0]       sum;
    logic [LCG_W-1:0]  lcg_q;
    logic [LCG_W-1:0]  lcg_nx;
    logic              accept;
    logic              no_range;

    assign accept   = req_i && (st_q == ST_IDLE || st_q == ST_DONE);
    assign no_range = (wired_q >= ENT_W);

    tlb_rand_lcg #(
        .W   (LCG_W),
        .MUL (LCG_MUL),
        .INC (LCG_INC)
    ) u_lcg (
        .clk     (clk),
        .rst     (rst),
        .step_i  (st_q == ST_ADVANCE),
        .state_o (lcg_q),
        .next_o  (lcg_nx)
    );

    tlb_rand_divstep #(
        .DW (WW)
    ) u_step (
        .part_i    (rem_q),
        .bit_i     (dividend_q[FOLD_W-1]),
        .divisor_i (divisor_q),
        .part_o    (rem_nx)
    );

    assign sum = {1'b0, rem_nx} + {1'b0, wired_q};

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (accept) st_d = ST_ADVANCE;
            ST_ADVANCE: st_d = no_range ? ST_DONE : ST_REDUCE;
            ST_REDUCE:  if (cnt_q == LAST_CNT) st_d = ST_DONE;
            ST_DONE:    if (accept) st_d = ST_ADVANCE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            wired_q    <= '0;
            divisor_q  <= '0;
            rem_q      <= '0;
            dividend_q <= '0;
            cnt_q      <= '0;
            idx_q      <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_DONE: begin
                    if (accept) wired_q <= wired_i;
                end
                ST_ADVANCE: begin
                    cnt_q      <= '0;
                    rem_q      <= '0;
                    dividend_q <= lcg_nx[LCG_W-1 -: FOLD_W];
                    divisor_q  <= ENT_W - wired_q;
                    if (no_range) idx_q <= LAST_IDX;
                end
                ST_REDUCE: begin
                    rem_q      <= rem_nx;
                    dividend_q <= dividend_q << 1;
                    cnt_q      <= cnt_q + 1'b1;
                    if (cnt_q == LAST_CNT) idx_q <= sum[IDXW-1:0];
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        valid_o = (st_q == ST_DONE);
        idx_o   = idx_q;
    end
endmodule

// File: rtl/tlb_rand_idx_chk.sv
`timescale 1ns/1ps
module tlb_rand_idx_chk #(
    parameter int unsigned ENTRIES = 48
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         req_i,
    input logic                         valid_o,
    input logic [$clog2(ENTRIES)-1:0]   idx_o,
    input logic [$clog2(ENTRIES+1)-1:0] wired_q,
    input logic [31:0]                  lcg_q,
    input tlb_rand_pkg::rnd_state_e     st_q
);
    import tlb_rand_pkg::*;

    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    a_r2_reset_clears: assert property (@(posedge clk)
        rst |=> (!valid_o && lcg_q == 32'd0 && st_q == ST_IDLE));

    a_r1_lcg_recurrence: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (lcg_q != $past(lcg_q)) |-> (lcg_q == $past(lcg_q) * LCG_MUL + LCG_INC));

    a_r8_busy_no_step: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (st_q == ST_REDUCE) |=> $stable(lcg_q));

    a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
        (valid_o && wired_q < ENTRIES) |-> (idx_o >= wired_q && idx_o < ENTRIES));

    a_r5_clamped: assert property (@(posedge clk) disable iff (rst)
        (valid_o && wired_q >= ENTRIES) |-> (idx_o == ENTRIES - 1));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !req_i) |=> (valid_o && $stable(idx_o)));

    a_r7_drop: assert property (@(posedge clk) disable iff (rst)
        (valid_o && req_i) |=> !valid_o);
endmodule

bind tlb_rand_idx tlb_rand_idx_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .valid_o (valid_o),
    .idx_o   (idx_o),
    .wired_q (wired_q),
    .lcg_q   (lcg_q),
    .st_q    (st_q)
);

// File: tb/tlb_rand_idx_tb.sv
`timescale 1ns/1ps
module tlb_rand_idx_tb;
    localparam int E    = 48;
    localparam int IDXW = $clog2(E);
    localparam int WW   = $clog2(E + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_i = 1'b0;
    logic [WW-1:0]   wired_i = '0;
    logic [IDXW-1:0] idx_o;
    logic            valid_o;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_seed = 32'd0;

    tlb_rand_idx #(.ENTRIES(E)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_i),
        .wired_i (wired_i),
        .idx_o   (idx_o),
        .valid_o (valid_o)
    );

    always #10 clk = ~clk;

    function automatic int exp_idx(input logic [31:0] s, input int w);
        if (w >= E) return E - 1;
        return int'(s[31:16]) % (E - w) + w;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One request with wired count w; optional late wired change and mid-run request
    task automatic do_req(input int w, input int poke_at, input int late_w);
        int n;
        int e;
        @(negedge clk);
        req_i   = 1'b1;
        wired_i = WW'(w);
        m_seed  = m_seed * 32'd314159 + 32'd1;   // R1 model
        e = exp_idx(m_seed, w);
        @(negedge clk);
        req_i = 1'b0;
        if (late_w >= 0) wired_i = WW'(late_w);  // R10 stimulus
        n = 1;
        check("R7 valid drops after accept", int'(valid_o), 0);
        while (!valid_o && n < 40) begin
            req_i = (n == poke_at);               // R8 stimulus
            @(negedge clk);
            n++;
        end
        req_i = 1'b0;
        check("R9 latency", n, (w >= E) ? 2 : 18);
        if (w >= E) check("R5 clamp", int'(idx_o), e);
        else        check("R3 index value", int'(idx_o), e);
        if (w < E) check("R4 range", int'(idx_o >= w && idx_o < E), 1);
    endtask

    task automatic hold_check(input int cycles);
        int v;
        v = int'(idx_o);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check("R6 valid held", int'(valid_o), 1);
            check("R6 index held", int'(idx_o), v);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R2 reset valid", int'(valid_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 idle after reset", int'(valid_o), 0);

        // directed corners
        do_req(0, 0, -1);          // seed 1 -> index 0
        hold_check(3);
        do_req(5, 0, -1);
        do_req(47, 0, -1);         // single legal slot
        do_req(E, 0, -1);          // clamp at equal
        do_req(63, 0, -1);         // clamp above
        do_req(10, 6, 40);         // R8 poke mid-run, R10 late change
        do_req(3, 2, 0);           // poke early in REDUCE
        hold_check(2);

        // reset during operation restarts sequence
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_seed = 32'd0;
        check("R2 valid low after reset", int'(valid_o), 0);
        do_req(5, 0, -1);          // seed 1 -> 0 % 43 + 5 = 5

        // constrained random
        for (int k = 0; k < 40; k++) begin
            int w;
            int p;
            w = int'($urandom_range(0, 52));
            p = ($urandom_range(0, 3) == 0) ? int'($urandom_range(2, 16)) : 0;
            do_req(w, p, ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 63)) : -1);
            if ($urandom_range(0, 3) == 0) hold_check(int'($urandom_range(1, 3)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #3000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule